// File: doc/BRIEF.md
# Burst Page-Boundary Splitter

This block sits between a burst source and a memory sequencer whose device does not allow a burst to run across a page boundary. It takes one request: a start byte address, a beat count and a beat-width code. It returns one or more sub-burst commands whose concatenation covers exactly the same beats. No command spans two pages. Each command carries its start address, its beat count and a flag that marks the final piece of the request.

The page size comes from a 3-bit configuration code. One code value turns splitting off, so a request passes through as a single command. The code and the beat width are captured when a request is accepted. A change to the configuration while the request is being split therefore has no effect on it. Code values that name no page size behave as "no splitting" and also set a sticky error flag.

Requests enter on a valid/ready handshake and commands leave on a second one. The block holds one request at a time. While a command waits for `out_ready`, it stays frozen on the outputs. The request address must be aligned to the beat width, and a request length of zero produces one zero-length command marked last.

Top module: `burst_page_splitter`

## Requirements
- R1: Out of reset, `in_ready` is 1, `out_valid` is 0 and `cfg_err` is 0.
- R2: Page code 0 disables splitting: the request is issued as one command with the request address, the full beat count and the last flag set, even when it spans boundaries.
- R3: Page code 1 selects a 128-byte page.
- R4: Page code 2 selects a 256-byte page.
- R5: Page code 4 selects a 1024-byte page.
- R6: With splitting active, the first command starts at the request address and has min(beats remaining, beats left before the next page boundary) beats. Every later command starts exactly on a page boundary and has the same min rule applied. A request that ends exactly on a boundary is not split further, and no command spans two pages.
- R7: Beat-width code 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes; code 3 is treated as 4 bytes. Each command's address equals the previous command's address plus its beat count times the beat width.
- R8: Page codes 3, 5, 6 and 7 behave as no splitting. In any cycle where `cfg_page` holds one of them, `cfg_err` becomes 1 on the next clock edge and stays 1 until reset.
- R9: `out_last` is 1 only on the final command of each request, and `in_ready` returns to 1 in the cycle after that command is taken.
- R10: From acceptance until the final command is handed off, `in_ready` is 0. While `out_valid` is 1 and `out_ready` is 0, the address, length and last flag remain unchanged.
- R11: The page code and beat width are sampled at request acceptance; changing `cfg_page` during the split does not alter the commands of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_page | input | 3 | Page-size code (0 off, 1 = 128 B, 2 = 256 B, 4 = 1024 B) |
| cfg_err | output | 1 | Sticky flag: a reserved page code was seen |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_addr | input | ADDR_W | Request start byte address, beat aligned |
| in_len | input | LEN_W | Request beat count |
| in_size | input | 2 | Beat-width code |
| out_valid | output | 1 | Command valid |
| out_ready | input | 1 | Command taken when high together with out_valid |
| out_addr | output | ADDR_W | Command start byte address |
| out_len | output | LEN_W | Command beat count |
| out_last | output | 1 | Final command of the request |

## Verification
The hardest case to reach is a request whose beats cross two or more boundaries while the consumer stalls at random. The middle commands are then full pages that begin on a boundary, and each must be held still across stalls. The stimulus reaches this with long requests at every page code and beat width, with start addresses a few beats below a boundary, and with a pseudo-random `out_ready`. A separate request changes `cfg_page` in the cycle after acceptance, which shows that the captured code still governs the later pieces.

// File: rtl/bps_pkg.sv
package bps_pkg;

    localparam int PG_CODE_W = 3;
    localparam int SZ_W      = 2;
    localparam int PSH_W     = 4;

    typedef enum logic [PG_CODE_W-1:0] {
        PG_OFF  = 3'd0,
        PG_SMALL = 3'd1,
        PG_MID  = 3'd2,
        PG_LARGE = 3'd4
    } pg_code_e;

    // Beat-width code to byte shift; the spare code maps to the widest beat.
    function automatic logic [SZ_W-1:0] beat_shift(input logic [SZ_W-1:0] sz);
        return (sz > 2'd2) ? 2'd2 : sz;
    endfunction

endpackage

// File: rtl/bps_page_decode.sv
module bps_page_decode
    import bps_pkg::*;
#(
    parameter int BASE_PSH = 7
) (
    input  logic [PG_CODE_W-1:0] code,
    output logic                 split,
    output logic [PSH_W-1:0]     psh,
    output logic                 rsvd
);

    always_comb begin
        split = 1'b0;
        psh   = '0;
        rsvd  = 1'b0;
        case (code)
            PG_OFF: ;
            PG_SMALL: begin
                split = 1'b1;
                psh   = PSH_W'(BASE_PSH);
            end
            PG_MID: begin
                split = 1'b1;
                psh   = PSH_W'(BASE_PSH + 1);
            end
            PG_LARGE: begin
                split = 1'b1;
                psh   = PSH_W'(BASE_PSH + 3);
            end
            default: rsvd = 1'b1;
        endcase
    end

endmodule

// File: rtl/bps_bound_calc.sv
module bps_bound_calc
    import bps_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 8,
    parameter int MAX_PSH = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  rem,
    input  logic [SZ_W-1:0]   bsh,
    input  logic              split,
    input  logic [PSH_W-1:0]  psh,
    output logic [LEN_W-1:0]  len,
    output logic              last
);

    localparam int OFS_W = MAX_PSH + 1;
    localparam int CMP_W = ((OFS_W > LEN_W) ? OFS_W : LEN_W) + 1;

    logic [OFS_W-1:0] page_bytes;
    logic [OFS_W-1:0] offset;
    logic [OFS_W-1:0] bytes_left;
    logic [CMP_W-1:0] beats_left;
    logic [CMP_W-1:0] rem_x;

    always_comb begin
        page_bytes = OFS_W'(1) << psh;
        offset     = addr[OFS_W-1:0] & (page_bytes - OFS_W'(1));
        bytes_left = page_bytes - offset;
        beats_left = CMP_W'(bytes_left >> bsh);
        rem_x      = CMP_W'(rem);
        if (!split || (beats_left >= rem_x)) begin
            len  = rem;
            last = 1'b1;
        end else begin
            len  = LEN_W'(beats_left);
            last = 1'b0;
        end
    end

endmodule

// File: rtl/burst_page_splitter.sv
module burst_page_splitter
    import bps_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 8,
    parameter int BASE_PSH = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PG_CODE_W-1:0] cfg_page,
    output logic                 cfg_err,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [ADDR_W-1:0]    in_addr,
    input  logic [LEN_W-1:0]     in_len,
    input  logic [SZ_W-1:0]      in_size,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [ADDR_W-1:0]    out_addr,
    output logic [LEN_W-1:0]     out_len,
    output logic                 out_last
);

    localparam int MAX_PSH = BASE_PSH + 3;

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic [SZ_W-1:0]   bsh;
        logic              split;
        logic [PSH_W-1:0]  psh;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    logic             dec_split;
    logic [PSH_W-1:0] dec_psh;
    logic             dec_rsvd;
    logic [LEN_W-1:0] sub_len;
    logic             sub_last;

    bps_page_decode #(.BASE_PSH(BASE_PSH)) u_decode (
        .code  (cfg_page),
        .split (dec_split),
        .psh   (dec_psh),
        .rsvd  (dec_rsvd)
    );

    bps_bound_calc #(
        .ADDR_W  (ADDR_W),
        .LEN_W   (LEN_W),
        .MAX_PSH (MAX_PSH)
    ) u_bound (
        .addr  (st_q.addr),
        .rem   (st_q.rem),
        .bsh   (st_q.bsh),
        .split (st_q.split),
        .psh   (st_q.psh),
        .len   (sub_len),
        .last  (sub_last)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = st_q.err | dec_rsvd;
        if (!st_q.busy) begin
            if (in_valid) begin
                st_d.busy  = 1'b1;
                st_d.addr  = in_addr;
                st_d.rem   = in_len;
                st_d.bsh   = beat_shift(in_size);
                st_d.split = dec_split;
                st_d.psh   = dec_psh;
            end
        end else if (out_ready) begin
            if (sub_last) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.addr = st_q.addr + (ADDR_W'(sub_len) << st_q.bsh);
                st_d.rem  = st_q.rem - sub_len;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = !st_q.busy;
    assign out_valid = st_q.busy;
    assign out_addr  = st_q.addr;
    assign out_len   = sub_len;
    assign out_last  = sub_last;
    assign cfg_err   = st_q.err;

    AST_FIRST_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && (out_addr == $past(in_addr))); // R6

    AST_NO_PAGE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && st_q.split && (out_len != '0) |->
        (((out_addr + (ADDR_W'(out_len) << st_q.bsh) - ADDR_W'(1)) >> st_q.psh)
            == (out_addr >> st_q.psh))); // R6

    AST_NEXT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last |=>
        out_valid && ((out_addr & ((ADDR_W'(1) << st_q.psh) - ADDR_W'(1))) == '0)); // R6

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=>
        out_valid && $stable(out_addr) && $stable(out_len) && $stable(out_last)); // R10

    AST_LAST_FREES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> in_ready); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R8

    AST_RSVD_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        dec_rsvd |=> cfg_err); // R8

endmodule

// File: tb/burst_page_splitter_tb_top.sv
module burst_page_splitter_tb_top;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              last;
    } cmd_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cfg_page = 3'd0;
    logic              cfg_err;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [LEN_W-1:0]  in_len = '0;
    logic [1:0]        in_size = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [ADDR_W-1:0] out_addr;
    logic [LEN_W-1:0]  out_len;
    logic              out_last;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   bp_mode  = 0;
    logic [15:0] lfsr = 16'hACE1;
    cmd_t exp_q[$];

    always #5 clk = ~clk;

    burst_page_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_page  (cfg_page),
        .cfg_err   (cfg_err),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_addr   (in_addr),
        .in_len    (in_len),
        .in_size   (in_size),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_addr  (out_addr),
        .out_len   (out_len),
        .out_last  (out_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference split computed from the requirements.
    task automatic push_expected(input int addr, input int len, input int size, input int code);
        int bw;
        int pb;
        int a;
        int rem;
        int n;
        bw  = (size >= 2) ? 4 : (1 << size);
        pb  = (code == 1) ? 128 : (code == 2) ? 256 : (code == 4) ? 1024 : 0;
        a   = addr;
        rem = len;
        do begin
            if (pb == 0) n = rem;
            else begin
                n = (pb - (a % pb)) / bw;
                if (n > rem) n = rem;
            end
            exp_q.push_back({ADDR_W'(a), LEN_W'(n), (n == rem)});
            a   = a + n * bw;
            rem = rem - n;
        end while (rem > 0);
    endtask

    task automatic send(input int addr, input int len, input int size, input int code);
        @(negedge clk);
        cfg_page = 3'(code);
        in_addr  = ADDR_W'(addr);
        in_len   = LEN_W'(len);
        in_size  = 2'(size);
        in_valid = 1'b1;
        push_expected(addr, len, size, code);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || !in_ready) @(negedge clk);
    endtask

    // Monitor: drives backpressure and scores every handed-off command.
    always @(negedge clk) begin
        if (rst_n) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (bp_mode)
                0:       out_ready = lfsr[0] | lfsr[3];
                1:       out_ready = 1'b0;
                default: out_ready = 1'b1;
            endcase
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected command addr", out_addr, 0);
                end else begin
                    cmd_t e;
                    e = exp_q.pop_front();
                    check(out_addr == e.addr && out_len == e.len && out_last == e.last,
                          "R6", $sformatf("cmd len %0d/%0d last %0d/%0d addr",
                                          out_len, e.len, out_last, e.last),
                          out_addr, e.addr);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [ADDR_W-1:0] h_addr;
        logic [LEN_W-1:0]  h_len;
        logic              h_last;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
        check(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        check(cfg_err == 1'b0, "R1", "cfg_err", cfg_err, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        send(32'h70, 40, 2, 0);    drain();  // R2 spans boundaries, one command
        send(32'h1F0, 20, 2, 1);   drain();  // R3 4 + 16
        send(32'h7F, 200, 0, 1);   drain();  // R3 1 + 128 + 71
        send(32'h2FC, 255, 1, 2);  drain();  // R4 R7 2 + 128 + 125
        send(32'h3F8, 255, 2, 4);  drain();  // R5 2 + 253
        send(32'h0, 200, 0, 4);    drain();  // R5 inside one page
        send(32'h100, 64, 2, 2);   drain();  // R6 ends exactly on boundary
        send(32'h78, 10, 3, 1);    drain();  // R7 width code 3 as 4 bytes: 2 + 8

        // R11 code changed right after acceptance: 16 + 32 + 32 + 20
        send(32'h40, 100, 2, 1);
        cfg_page = 3'd0;
        drain();

        // R10 stall: hold outputs and block input
        bp_mode = 1;
        send(32'h7C, 30, 2, 1);
        h_addr = out_addr;
        h_len  = out_len;
        h_last = out_last;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(in_ready == 1'b0 && out_valid == 1'b1, "R10", "busy ready/valid",
                  {in_ready, out_valid}, 2'b01);
            check(out_addr == h_addr && out_len == h_len && out_last == h_last,
                  "R10", "held command addr", out_addr, h_addr);
        end
        bp_mode = 0;
        drain();
        @(negedge clk);
        check(in_ready == 1'b1, "R9", "in_ready after last", in_ready, 1);

        // R8 reserved code: no split, sticky flag
        check(cfg_err == 1'b0, "R8", "cfg_err before reserved", cfg_err, 0);
        send(32'h70, 40, 2, 5);    drain();  // R8 single command
        check(cfg_err == 1'b1, "R8", "cfg_err after reserved", cfg_err, 1);
        cfg_page = 3'd1;
        repeat (3) @(negedge clk);
        check(cfg_err == 1'b1, "R8", "cfg_err sticky", cfg_err, 1);
        send(32'h3C, 40, 1, 7);    drain();  // R8 single command
        bp_mode = 2;
        send(32'h1FC, 70, 2, 1);   drain();  // R3 1 + 32 + 32 + 5 at full rate
        bp_mode = 0;

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9", "pending expected commands", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule